// File: doc/BRIEF.md
# Deferred-Destination Pipelined Load Unit

This block is a load unit that leaves memory latency visible to the issuer. Each pipelined load issue supplies exactly one address, which goes out as a memory read in the same cycle. The address passes through unchanged, and the unit never increments it, so any stride or gather pattern is produced by whoever drives the issue port. The register that receives a load's data is not named when that load is issued. It is named by the issue two loads later. That later issue carries its own new address and also the destination tag for the oldest outstanding load, whose data is written out on the register write port in that same cycle.

The unit holds at most two outstanding loads. It connects to a memory that returns read data in order, a fixed number of cycles after the request. The pipeline advances only on an issue or a drain, never on its own. If an issue would retire the oldest load before that load's data has arrived, the unit holds the issue off with a ready signal until the data is in. A drain request retires the oldest remaining load to a tag supplied with the drain, without starting a memory read. This lets software empty the pipeline at the end of a sequence.

The control is a three-state machine counting the outstanding loads: `S_EMPTY`, `S_ONE` and `S_FULL`. The transitions are `ISSUE_FIRST` (S_EMPTY to S_ONE), `ISSUE_SECOND` (S_ONE to S_FULL), `ISSUE_ROLL` (S_FULL to S_FULL, retiring one load and accepting one), `DRAIN_LAST` (S_ONE to S_EMPTY) and `DRAIN_OLDEST` (S_FULL to S_ONE). In every other case the state holds.

Top module: `dld_unit`

## Requirements
- R1: After reset `iss_rdy` is 1, `wr_en` is 0 and `mem_req` is 0.
- R2: An accepted issue (`iss_vld` and `iss_rdy` both 1) raises `mem_req` in the same cycle, with `mem_addr` equal to `iss_addr` unchanged. No memory read starts in any other cycle.
- R3: The first two issues after the pipeline is empty produce no register write, and the tags given with them have no effect.
- R4: An accepted issue made while two loads are outstanding raises `wr_en` in the same cycle, with `wr_tag` equal to that issue's `iss_tag` and `wr_data` equal to the data returned for the oldest outstanding load.
- R5: Register writes carry data in issue order: the k-th write carries the data of the k-th issued load, for strided and random-index address sequences alike.
- R6: When two loads are outstanding and the oldest load's data has not yet returned, `iss_rdy` is 0. A held issue then causes no memory read and no register write.
- R7: With `iss_vld` at 0, `drain` at 1 and at least one load outstanding whose data has returned, the oldest load is written with `wr_tag` equal to `drn_tag`, and no memory read starts.
- R8: A drain has no effect when nothing is outstanding, and it is ignored in any cycle in which `iss_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Pipelined load issue request |
| iss_addr | input | 32 | Address of the load being issued |
| iss_tag | input | 5 | Destination tag for the load issued two issues earlier |
| iss_rdy | output | 1 | Issue can be accepted this cycle |
| drain | input | 1 | Retire the oldest load without a new read |
| drn_tag | input | 5 | Destination tag used by a drain |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid (in order) |
| mem_rdata | input | 32 | Memory read data |
| wr_en | output | 1 | Register write enable |
| wr_tag | output | 5 | Register write destination tag |
| wr_data | output | 32 | Register write data |

## Verification
If the state counter is wrong, the fault shows at the ports in the same cycle as the next issue: either a write appears on one of the first two issues, or a write goes missing on the third. If the slot data is wrong, the next write carries another load's data or loads come out of order. If the data-arrival flag is wrong, `iss_rdy` drops in a cycle where the data is already present, or stays high where it is not. The tests therefore compare every issue and every drain against a model of outstanding addresses kept in the bench, covering strided, gathered and back-to-back patterns.

// File: rtl/dld_pkg.sv
package dld_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_ONE   = 2'd1,
        S_FULL  = 2'd2
    } dld_state_e;
endpackage

// File: rtl/dld_ctrl.sv
module dld_ctrl
    import dld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iss_vld,
    input  logic       drain,
    input  logic       head_got,
    output dld_state_e st,
    output logic       iss_rdy,
    output logic       push,
    output logic       retire
);
    dld_state_e st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        iss_rdy = (st != S_FULL) || head_got;
        push    = iss_vld && iss_rdy;
        retire  = 1'b0;
        st_nx   = st;
        unique case (st)
            S_EMPTY: begin
                if (push) st_nx = S_ONE;                 // ISSUE_FIRST
            end
            S_ONE: begin
                if (push) st_nx = S_FULL;                // ISSUE_SECOND
                else if (drain && head_got) begin
                    retire = 1'b1;
                    st_nx  = S_EMPTY;                    // DRAIN_LAST
                end
            end
            S_FULL: begin
                if (push) retire = 1'b1;                 // ISSUE_ROLL
                else if (!iss_vld && drain && head_got) begin
                    retire = 1'b1;
                    st_nx  = S_ONE;                      // DRAIN_OLDEST
                end
            end
            default: st_nx = S_EMPTY;
        endcase
    end

    // R3
    first_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EMPTY && iss_vld) |=> (st == S_ONE));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FULL && iss_vld && !iss_rdy) |=> (st == S_FULL));
endmodule

// File: rtl/dld_slots.sv
module dld_slots
    import dld_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dld_state_e        st,
    input  logic              push,
    input  logic              retire,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              head_got,
    output logic [DATA_W-1:0] head_data
);
    logic              got0, got1, ng0, ng1;
    logic [DATA_W-1:0] d0, d1, nd0, nd1;
    logic [1:0]        occ;

    always_comb begin
        ng0 = got0; ng1 = got1; nd0 = d0; nd1 = d1;
        occ = (st == S_FULL) ? 2'd2 : (st == S_ONE) ? 2'd1 : 2'd0;
        if (mem_rvalid) begin
            if (occ != 2'd0 && !got0) begin
                ng0 = 1'b1; nd0 = mem_rdata;
            end else if (occ == 2'd2 && !got1) begin
                ng1 = 1'b1; nd1 = mem_rdata;
            end
        end
        if (retire) begin
            ng0 = ng1; nd0 = nd1; ng1 = 1'b0;
            occ = occ - 2'd1;
        end
        if (push) begin
            if (occ == 2'd0) ng0 = 1'b0;
            else             ng1 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got0 <= 1'b0; got1 <= 1'b0;
            d0   <= '0;   d1   <= '0;
        end else begin
            got0 <= ng0; got1 <= ng1;
            d0   <= nd0; d1   <= nd1;
        end
    end

    assign head_got  = got0;
    assign head_data = d0;

    // R4
    retire_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> got0);

    // R5
    rvalid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (st != S_EMPTY));
endmodule

// File: rtl/dld_unit.sv
module dld_unit
    import dld_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [TAG_W-1:0]  iss_tag,
    output logic              iss_rdy,
    input  logic              drain,
    input  logic [TAG_W-1:0]  drn_tag,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);
    dld_state_e        st;
    logic              push, retire, head_got;
    logic [DATA_W-1:0] head_data;

    dld_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .drain(drain),
        .head_got(head_got), .st(st), .iss_rdy(iss_rdy),
        .push(push), .retire(retire)
    );

    dld_slots #(.DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .st(st), .push(push), .retire(retire),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .head_got(head_got), .head_data(head_data)
    );

    always_comb begin
        mem_req  = push;
        mem_addr = iss_addr;
        wr_en    = retire;
        wr_tag   = iss_vld ? iss_tag : drn_tag;
        wr_data  = head_data;
    end

    // R2
    read_only_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> iss_vld);

    // R7
    drain_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !iss_vld) |-> !mem_req);
endmodule

// File: tb/dld_unit_tb.sv
module dld_unit_tb;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_vld = 1'b0;
    logic [31:0] iss_addr = '0;
    logic [4:0]  iss_tag = '0;
    logic        iss_rdy;
    logic        drain = 1'b0;
    logic [4:0]  drn_tag = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        wr_en;
    logic [4:0]  wr_tag;
    logic [31:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dld_unit u_dut (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_addr(iss_addr),
        .iss_tag(iss_tag), .iss_rdy(iss_rdy), .drain(drain), .drn_tag(drn_tag),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'hA5C3_0F1E;
    endfunction

    logic        sh_v [LAT];
    logic [31:0] sh_a [LAT];
    always_ff @(posedge clk) begin
        for (int i = 0; i < LAT; i++) begin
            if (!rst_n) begin
                sh_v[i] <= 1'b0; sh_a[i] <= '0;
            end else if (i == 0) begin
                sh_v[0] <= mem_req; sh_a[0] <= mem_addr;
            end else begin
                sh_v[i] <= sh_v[i-1]; sh_a[i] <= sh_a[i-1];
            end
        end
    end
    assign mem_rvalid = sh_v[LAT-1];
    assign mem_rdata  = memf(sh_a[LAT-1]);

    logic [31:0] q [2];
    int          qn = 0;
    bit          last_stalled;

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_issue(input logic [31:0] a, input logic [4:0] t, input bit with_drain);
        @(negedge clk);
        iss_vld = 1'b1; iss_addr = a; iss_tag = t;
        drain = with_drain; drn_tag = ~t;
        last_stalled = 1'b0;
        #1;
        while (!iss_rdy) begin
            last_stalled = 1'b1;
            check(qn == 2, "R6 stall only when full", 32'(qn), 32'd2);
            check(!mem_req && !wr_en, "R6 held issue silent", {30'd0, mem_req, wr_en}, 32'd0);
            @(negedge clk); #1;
        end
        check(mem_req && mem_addr == a, "R2 read address", mem_addr, a);
        if (qn == 2) begin
            check(wr_en == 1'b1, "R4 write on third issue", 32'(wr_en), 32'd1);
            check(wr_tag == t, with_drain ? "R8 issue tag wins over drain" : "R4 tag",
                  32'(wr_tag), 32'(t));
            check(wr_data == memf(q[0]), "R5 data order", wr_data, memf(q[0]));
            q[0] = q[1]; q[1] = a;
        end else begin
            check(wr_en == 1'b0, "R3 no write on first two", 32'(wr_en), 32'd0);
            q[qn] = a; qn++;
        end
        @(posedge clk); #1;
        iss_vld = 1'b0; drain = 1'b0;
    endtask

    task automatic do_drain(input logic [4:0] t);
        @(negedge clk);
        drain = 1'b1; drn_tag = t;
        #1;
        if (qn == 0) begin
            for (int i = 0; i < 3; i++) begin
                check(!wr_en && !mem_req, "R8 drain on empty", {30'd0, wr_en, mem_req}, 32'd0);
                @(negedge clk); #1;
            end
        end else begin
            while (!wr_en) begin @(negedge clk); #1; end
            check(!mem_req, "R7 drain starts no read", 32'(mem_req), 32'd0);
            check(wr_tag == t, "R7 drain tag", 32'(wr_tag), 32'(t));
            check(wr_data == memf(q[0]), "R7 drain data", wr_data, memf(q[0]));
            q[0] = q[1]; qn--;
        end
        @(posedge clk); #1;
        drain = 1'b0;
    endtask

    task automatic t_reset();
        check(iss_rdy == 1'b1, "R1 ready", 32'(iss_rdy), 32'd1);
        check(wr_en == 1'b0, "R1 no write", 32'(wr_en), 32'd0);
        check(mem_req == 1'b0, "R1 no read", 32'(mem_req), 32'd0);
    endtask

    task automatic t_tags_ignored();
        do_issue(32'h0000_1000, 5'd7, 1'b0);
        do_issue(32'h0000_1004, 5'd9, 1'b0);
        do_drain(5'd1);
        do_drain(5'd2);
    endtask

    task automatic t_strided();
        for (int i = 0; i < 10; i++)
            do_issue(32'h2000_0000 + 32'(i) * 32'd24, 5'(i + 3), 1'b0);
        do_drain(5'd30);
        do_drain(5'd31);
    endtask

    task automatic t_gather();
        for (int i = 0; i < 12; i++)
            do_issue(32'h4000_0000 + ((32'(i) * 37 + 11) % 64) * 4, 5'(i * 5), 1'b0);
        do_drain(5'd4);
        do_drain(5'd6);
    endtask

    task automatic t_stall();
        bit saw = 1'b0;
        do_issue(32'h0000_0100, 5'd0, 1'b0);
        do_issue(32'h0000_0200, 5'd0, 1'b0);
        do_issue(32'h0000_0300, 5'd11, 1'b0);
        saw = last_stalled;
        check(saw, "R6 back-to-back third issue stalls", 32'(saw), 32'd1);
        do_drain(5'd12);
        do_drain(5'd13);
    endtask

    task automatic t_drain_rules();
        do_drain(5'd3);
        do_issue(32'h0000_5000, 5'd0, 1'b1);
        do_drain(5'd20);
        do_drain(5'd21);
        do_issue(32'h0000_6000, 5'd0, 1'b0);
        do_issue(32'h0000_6008, 5'd0, 1'b1);
        do_issue(32'h0000_6010, 5'd17, 1'b1);
        do_drain(5'd22);
        do_drain(5'd23);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tags_ignored();
        t_strided();
        t_gather();
        t_stall();
        t_drain_rules();
        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule